// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte path of an Ethernet MAC and decides, once per frame, whether the frame is kept or discarded. It looks at the six destination-address bytes at the head of the frame. It sorts each frame as broadcast (all ones), multicast (low bit of the first octet set, not all ones) or unicast. Each class is judged by its own rule, and the frame length is also compared against a programmable maximum.

Bytes arrive one per cycle when `in_valid` is high. `in_sof` marks the first byte of a frame and `in_eof` marks the last byte. The destination verdict is complete once the sixth byte has been seen. One cycle after the last byte, the block raises `dec_valid` for a single cycle. `dec_accept` carries the verdict in that cycle. The station address and policy words come from an external register file. That register file is expected to reset both don't-care bits to 1 and the maximum length to 0x600.

Top module: `rx_da_filter`

## Requirements
- R1: A unicast destination is accepted when all six bytes match the station address. The mapping is: `sta_a[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` are wire bytes 1 to 4, and `sta_b[31:24]` and `[23:16]` are bytes 5 and 6. `sta_b[15:0]` is unused.
- R2: A unicast destination that differs from the station address in any byte is dropped.
- R3: A destination of six 0xFF bytes is broadcast. It is dropped only when `pol_drop[9]` is 1 and `pol_dc[9]` is 0. The multicast bits have no effect on it.
- R4: A destination that is not broadcast and whose first byte has bit 0 set is multicast. It is dropped only when `pol_drop[8]` is 1 and `pol_dc[8]` is 0. The broadcast bits have no effect on it.
- R5: A frame whose total byte count exceeds `max_len[LEN_W-1:0]` is dropped. A frame whose count equals that value can be accepted. With the default, LEN_W is 16.
- R6: A frame of fewer than six bytes is dropped.
- R7: `dec_valid` is high for exactly one cycle, in the cycle after the byte carrying `in_eof` is taken. `dec_accept` is low whenever `dec_valid` is low. Cycles with `in_valid` low are ignored.
- R8: The internal byte count saturates at 2^(LEN_W+1)-1. A frame longer than that is therefore still dropped by R5 and does not wrap around.
- R9: A valid byte outside a frame (no `in_sof` since the last `in_eof`) is ignored. An `in_sof` in the middle of a frame abandons that frame without a verdict and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| sta_a | input | 32 | Station address bytes 1..4 |
| sta_b | input | 32 | Station address bytes 5..6 in [31:16] |
| pol_drop | input | 32 | Drop bits: [9] broadcast, [8] multicast |
| pol_dc | input | 32 | Don't-care bits: [9] broadcast, [8] multicast |
| max_len | input | 32 | Maximum frame length in [LEN_W-1:0] |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
Some properties are checked on every cycle. The verdict strobe must follow a taken end-of-frame byte by exactly one cycle, and acceptance must never appear without the strobe. A separate byte counter in the checker forbids acceptance of any frame that was too short or over the length limit. The address classification is shown only by the bench's scenarios: exact versus near-miss unicast, every drop/don't-care combination for broadcast and multicast, and the independence of the two classes. The same holds for the saturating counter, for stray bytes and for restarted frames.

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic [31:0] sta_a,
  input  logic [31:0] sta_b,
  input  logic [31:0] pol_drop,
  input  logic [31:0] pol_dc,
  input  logic [31:0] max_len,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam int CNT_W = LEN_W + 1;
  localparam int BC_BIT = 9;
  localparam int MC_BIT = 8;
  localparam logic [CNT_W-1:0] DA_BYTES = CNT_W'(6);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt, cnt_nx, idx;
  logic active, bc, mc, mt, bc_nx, mc_nx, mt_nx;
  logic [7:0] ref_oct;
  logic addr_ok, len_ok;

  wire take = in_valid & (in_sof | active);
  assign idx = in_sof ? '0 : cnt;

  always_comb begin
    case (idx)
      CNT_W'(0): ref_oct = sta_a[31:24];
      CNT_W'(1): ref_oct = sta_a[23:16];
      CNT_W'(2): ref_oct = sta_a[15:8];
      CNT_W'(3): ref_oct = sta_a[7:0];
      CNT_W'(4): ref_oct = sta_b[31:24];
      CNT_W'(5): ref_oct = sta_b[23:16];
      default:   ref_oct = 8'h00;
    endcase
  end

  always_comb begin
    bc_nx = bc; mc_nx = mc; mt_nx = mt; cnt_nx = cnt;
    if (in_sof) begin
      bc_nx  = (in_data == 8'hFF);
      mt_nx  = (in_data == ref_oct);
      mc_nx  = in_data[0];
      cnt_nx = CNT_W'(1);
    end else begin
      if (cnt < DA_BYTES) begin
        bc_nx = bc & (in_data == 8'hFF);
        mt_nx = mt & (in_data == ref_oct);
      end
      if (cnt != CNT_TOP) cnt_nx = cnt + CNT_W'(1);
    end
  end

  assign addr_ok = bc_nx ? !(pol_drop[BC_BIT] & !pol_dc[BC_BIT]) :
                   mc_nx ? !(pol_drop[MC_BIT] & !pol_dc[MC_BIT]) : mt_nx;
  assign len_ok  = (cnt_nx >= DA_BYTES) && (cnt_nx <= {1'b0, max_len[LEN_W-1:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; active <= 1'b0;
      bc <= 1'b0; mc <= 1'b0; mt <= 1'b0;
      dec_valid <= 1'b0; dec_accept <= 1'b0;
    end else begin
      dec_valid  <= take & in_eof;
      dec_accept <= take & in_eof & addr_ok & len_ok;
      if (take) begin
        cnt <= cnt_nx; bc <= bc_nx; mc <= mc_nx; mt <= mt_nx;
        active <= !in_eof;
      end
    end
  end
endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk #(
  parameter int LEN_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sof,
  input logic        in_eof,
  input logic [31:0] max_len,
  input logic        dec_valid,
  input logic        dec_accept
);
  localparam int CW = LEN_W + 1;
  logic [CW-1:0] c, n;
  logic act, short_q, long_q;
  wire fin = in_valid & in_eof & (in_sof | act);

  assign n = in_sof ? CW'(1) : ((c == '1) ? c : c + CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c <= '0; act <= 1'b0; short_q <= 1'b0; long_q <= 1'b0;
    end else begin
      if (in_valid & (in_sof | act)) begin
        c <= n; act <= !in_eof;
      end
      short_q <= fin && (n < CW'(6));
      long_q  <= fin && (n > {1'b0, max_len[LEN_W-1:0]});
    end
  end

  assert_strobe_follows_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_eof));
  assert_accept_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid || $past(fin));
  assert_no_short_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> !short_q);
  assert_no_long_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> !long_q);
endmodule

bind rx_da_filter rx_da_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .max_len(max_len), .dec_valid(dec_valid), .dec_accept(dec_accept));

// File: tb/tb_rx_da_filter.sv
module tb_rx_da_filter;
  localparam int LW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic [31:0] sta_a = 32'h02AABBCC, sta_b = 32'hDDEE0000;
  logic [31:0] pol_drop = 0, pol_dc = 32'h300, max_len = 32'd64;
  logic dec_valid, dec_accept;

  int n_chk = 0, n_bad = 0;
  bit exp_q[$];
  string tag_q[$];

  localparam logic [47:0] ME = 48'h02AABBCCDDEE;
  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC = 48'h01005E000001;

  rx_da_filter #(.LEN_W(LW)) dut (.*);

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7/R9: unexpected verdict, actual accept=%0b expected none", dec_accept);
      end else begin
        bit e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (dec_accept !== e) begin
          n_bad++;
          $display("FAIL %s: accept actual %0b expected %0b", t, dec_accept, e);
        end
      end
    end
  end

  task automatic drive(input logic [7:0] b, input bit s, input bit e);
    @(posedge clk); #1;
    in_valid = 1; in_data = b; in_sof = s; in_eof = e;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic send(input logic [47:0] da, input int len, input bit exp, input string t,
                      input bit gaps = 0);
    exp_q.push_back(exp); tag_q.push_back(t);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = (i < 6) ? da[47-8*i -: 8] : 8'(i);
      drive(b, i == 0, i == len - 1);
      if (gaps && i != len - 1) idle();
    end
    idle();
    @(negedge clk);
    n_chk++;
    if (dec_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R7 (%s): strobe one cycle after eof, actual %0b expected 1", t, dec_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (dec_valid !== 0 || dec_accept !== 0) begin
      n_bad++;
      $display("FAIL R7: reset outputs actual %0b%0b expected 00", dec_valid, dec_accept);
    end

    send(ME, 60, 1, "R1 exact match");
    send(48'h02AABBCCDDEF, 60, 0, "R2 last byte differs");
    send(48'h06AABBCCDDEE, 60, 0, "R2 first byte differs");
    send(48'h02AABBCCDDEE, 60, 1, "R1 match with gaps", 1);

    pol_drop = 0; pol_dc = 0;
    send(BC, 60, 1, "R3 bcast drop=0 dc=0");
    pol_drop = 32'h200; pol_dc = 32'h200;
    send(BC, 60, 1, "R3 bcast drop=1 dc=1");
    pol_dc = 0;
    send(BC, 60, 0, "R3 bcast drop=1 dc=0");
    pol_drop = 32'h100; pol_dc = 0;
    send(BC, 60, 1, "R3 bcast ignores mcast bits");

    pol_drop = 0; pol_dc = 0;
    send(MC, 60, 1, "R4 mcast drop=0 dc=0");
    pol_drop = 32'h100; pol_dc = 32'h100;
    send(MC, 60, 1, "R4 mcast drop=1 dc=1");
    pol_dc = 0;
    send(MC, 60, 0, "R4 mcast drop=1 dc=0");
    pol_drop = 32'h200; pol_dc = 0;
    send(MC, 60, 1, "R4 mcast ignores bcast bits");
    pol_drop = 0; pol_dc = 32'h300;

    max_len = 32'h0000_0140;
    send(ME, 64, 1, "R5 low field 0x40 used, len 64");
    max_len = 32'd64;
    send(ME, 65, 0, "R5 len one over max");
    send(BC, 65, 0, "R5 bcast over max");

    send(ME, 5, 0, "R6 five bytes");
    send(ME, 6, 1, "R6 six bytes");
    send(ME, 1, 0, "R6 single byte sof+eof");

    max_len = 32'hFF;
    send(ME, 255, 1, "R8 len equal to field max");
    send(ME, 520, 0, "R8 len past counter wrap");

    drive(8'hFF, 0, 0); drive(8'h11, 0, 1); idle();
    repeat (2) @(negedge clk);
    n_chk++;
    if (dec_valid !== 0) begin
      n_bad++;
      $display("FAIL R9: stray bytes gave verdict, actual %0b expected 0", dec_valid);
    end
    drive(8'h55, 1, 0); drive(8'h66, 0, 0); drive(8'h77, 0, 0);
    send(ME, 20, 1, "R9 restart after abandoned frame");

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7: verdicts missing, actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule